// File: doc/BRIEF.md
# Serial Transmitter with Automatic Half-Duplex Driver Enable

This block is the transmit side of an asynchronous serial port that feeds a half-duplex differential line transceiver. Software or an upstream engine pushes bytes into a 16-entry queue. A shift sequencer sends each byte as one frame: a low start bit, eight data bits least-significant first, and a high stop bit. Every bit lasts one period of an external baud tick, and the line idles high.

The transceiver's driver-enable line is generated entirely in hardware. It selects transmit as soon as a byte has been accepted into the queue. It stays on transmit while the queue or the shift sequencer holds data. After the last stop bit it holds transmit for a fixed guard of three bit periods, and only then does it hand the bus back to receive. A byte that leaves an idle sequencer is preceded by one full bit period of idle-high line with the driver already enabled, so the far end sees a settled line before the start bit.

A byte that arrives during the guard cancels the countdown, and the driver stays enabled for the new frame. The enable can be made active-high or active-low, and it can be switched off entirely. When it is switched off, the serial output keeps working. The guard length is a build-time parameter and is not writable at run time.

Top module: `uart485_tx`

## Requirements
- R1: The frame on `tx_o` is a start bit at 0, then eight data bits with bit 0 first, then a stop bit at 1. Each bit lasts exactly one baud-tick period. The line is 1 whenever the block is not sending a frame.
- R2: The internal transmit direction is active whenever the queue is non-empty or the sequencer is busy. It becomes active in the first cycle after a write is accepted.
- R3: When the stop bit of the last queued frame ends, the transmit direction stays active for three more baud ticks. It drops on the third tick edge, which is exactly 13 tick periods after the edge that began that frame's start bit.
- R4: A byte loaded into an idle sequencer waits for the next baud tick. The line then stays high for one full tick period before the start bit, so the start bit always begins on a tick edge and at least one bit period after the direction became active.
- R5: If another byte is queued when a stop bit ends, its start bit begins on that same tick edge, 10 tick periods after the previous start bit, and the direction stays active without a gap.
- R6: A write accepted during the guard cancels the countdown. The direction stays active without a gap, and the new byte is sent.
- R7: With `de_pol_i`=1 the transmit direction is driven as 1 on `de_o` and receive as 0. With `de_pol_i`=0 the two levels are swapped.
- R8: With `dir_hw_en_i`=0, `de_o` holds the receive level (the inverse of `de_pol_i`) at all times, and frames are still sent on `tx_o`.
- R9: The queue holds 16 bytes. `full_o` is 1 exactly when 16 bytes are held, and `empty_o` is 1 exactly when none are held. The byte being shifted is not counted.
- R10: A write while `full_o`=1 is discarded and sets `overflow_o`. `overflow_o` stays at 1 until reset.
- R11: After reset, `tx_o`=1, `de_o` is at the receive level, `empty_o`=1, `full_o`=0 and `overflow_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, pushes `wdata_i` into the queue |
| wdata_i | input | 8 | Byte to send |
| baud_tick_i | input | 1 | One-cycle pulse per bit period |
| dir_hw_en_i | input | 1 | Enables automatic driver-enable control |
| de_pol_i | input | 1 | Level of `de_o` that means transmit |
| tx_o | output | 1 | Serial data line |
| de_o | output | 1 | Transceiver driver enable |
| full_o | output | 1 | Queue holds 16 bytes |
| empty_o | output | 1 | Queue holds no bytes |
| overflow_o | output | 1 | Sticky flag for a discarded write |

## Verification
Some rules are checked by assertions on every cycle:
- the line rests high whenever the direction is receive;
- the direction covers all queue and sequencer activity;
- the direction only falls, and a start bit only begins, on a tick edge;
- a write into a full queue raises the sticky overflow flag;
- full and empty never occur together.

The exact three-tick guard length and the one-bit lead are measured only by the bench scenarios. So are the gap-free hand-over between back-to-back frames, the cancellation of the guard by a late write, the polarity and disable modes, and the bytes actually carried on the line.

// File: rtl/uart485_pkg.sv
package uart485_pkg;
  typedef enum logic [2:0] {
    SH_IDLE,
    SH_ALIGN,
    SH_LEAD,
    SH_START,
    SH_DATA,
    SH_STOP
  } sh_state_e;
endpackage

// File: rtl/uart485_fifo.sv
module uart485_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_ok   = wr_i && !full_o;
  assign rd_ok   = rd_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      // discarded write latches until reset
      if (wr_i && full_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart485_shifter.sv
module uart485_shifter
  import uart485_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          avail_i,
  input  logic [DW-1:0] data_i,
  output logic          pop_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          tx_o
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  sh_state_e     state_q;
  logic [DW-1:0] sh_q;
  logic [BW-1:0] idx_q;
  logic          pop_idle, pop_chain;

  assign pop_idle  = (state_q == SH_IDLE) && avail_i;
  assign pop_chain = (state_q == SH_STOP) && tick_i && avail_i;
  assign pop_o     = pop_idle || pop_chain;
  assign done_o    = (state_q == SH_STOP) && tick_i && !avail_i;
  assign busy_o    = (state_q != SH_IDLE);

  always_comb begin
    case (state_q)
      SH_START: tx_o = 1'b0;
      SH_DATA:  tx_o = sh_q[0];
      default:  tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SH_IDLE: if (pop_idle) begin
          sh_q    <= data_i;
          state_q <= SH_ALIGN;
        end
        // wait for a bit boundary, then hold one full idle bit
        SH_ALIGN: if (tick_i) state_q <= SH_LEAD;
        SH_LEAD:  if (tick_i) state_q <= SH_START;
        SH_START: if (tick_i) begin
          idx_q   <= '0;
          state_q <= SH_DATA;
        end
        SH_DATA: if (tick_i) begin
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + BW'(1);
          if (idx_q == BW'(DW - 1)) state_q <= SH_STOP;
        end
        SH_STOP: if (tick_i) begin
          if (avail_i) begin
            sh_q    <= data_i;
            state_q <= SH_START;
          end else begin
            state_q <= SH_IDLE;
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart485_dir.sv
module uart485_dir #(
  parameter int GUARD_BITS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic busy_i,
  input  logic done_i,
  output logic dir_o
);
  localparam int GW = $clog2(GUARD_BITS + 1);

  logic [GW-1:0] guard_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      guard_q <= '0;
    end else if (done_i) begin
      guard_q <= GW'(GUARD_BITS);
    end else if (busy_i) begin
      guard_q <= '0;
    end else if (tick_i && guard_q != '0) begin
      guard_q <= guard_q - GW'(1);
    end
  end

  assign dir_o = busy_i || (guard_q != '0);
endmodule

// File: rtl/uart485_tx.sv
module uart485_tx
  import uart485_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int GUARD_BITS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              baud_tick_i,
  input  logic              dir_hw_en_i,
  input  logic              de_pol_i,
  output logic              tx_o,
  output logic              de_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o
);
  logic [DATA_W-1:0] q_data;
  logic              pop, sh_busy, sh_done, busy, tx_dir;

  uart485_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rd_i    (pop),
    .rdata_o (q_data),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (overflow_o)
  );

  uart485_shifter #(.DW(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .avail_i (!empty_o),
    .data_i  (q_data),
    .pop_o   (pop),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .tx_o    (tx_o)
  );

  assign busy = !empty_o || sh_busy;

  uart485_dir #(.GUARD_BITS(GUARD_BITS)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .busy_i (busy),
    .done_i (sh_done),
    .dir_o  (tx_dir)
  );

  assign de_o = (dir_hw_en_i && tx_dir) ? de_pol_i : !de_pol_i;
endmodule

// File: rtl/uart485_tx_chk.sv
module uart485_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic baud_tick_i,
  input logic tx_o,
  input logic full_o,
  input logic empty_o,
  input logic overflow_o,
  input logic tx_dir_i,
  input logic busy_i
);
  AST_LINE_HIGH_IN_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_dir_i |-> tx_o);  // R1
  AST_BUSY_KEEPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> tx_dir_i);  // R2
  AST_DIR_FALL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_dir_i) |-> $past(baud_tick_i));  // R3
  AST_START_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_o) |-> $past(baud_tick_i));  // R4
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));  // R9
  AST_OVF_ON_FULL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o) |=> overflow_o);  // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);  // R10
endmodule

bind uart485_tx uart485_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .baud_tick_i (baud_tick_i),
  .tx_o        (tx_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .overflow_o  (overflow_o),
  .tx_dir_i    (tx_dir),
  .busy_i      (busy)
);

// File: tb/uart485_tx_test.sv
`timescale 1ns/1ps
module uart485_tx_test;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       tick = 1'b0;
  logic       hw_en = 1'b1;
  logic       pol = 1'b1;
  logic       tx, de, full, empty, ovf;

  int  checks = 0;
  int  failures = 0;
  int  cyc = 0;
  bit  watch_en = 1'b0;
  logic watch_lvl = 1'b0;
  int  gap = 0;
  bit  finished = 1'b0;

  uart485_tx uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_i        (wr),
    .wdata_i     (wdata),
    .baud_tick_i (tick),
    .dir_hw_en_i (hw_en),
    .de_pol_i    (pol),
    .tx_o        (tx),
    .de_o        (de),
    .full_o      (full),
    .empty_o     (empty),
    .overflow_o  (ovf)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int dc = 0;
    forever begin
      @(negedge clk);
      tick = (dc == DIV - 1);
      dc = (dc == DIV - 1) ? 0 : dc + 1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (watch_en && de !== watch_lvl) gap++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr = 1'b1;
    wdata = b;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, output int fall_cyc);
    bit seen = 1'b0;
    b = '0;
    fall_cyc = cyc;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (tx === 1'b0) begin
        seen = 1'b1;
        fall_cyc = cyc;
      end
    end
    chk(seen, "R1 start bit seen", int'(seen), 1);
    repeat (DIV / 2) @(negedge clk);
    chk(tx === 1'b0, "R1 start bit low", int'(tx), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = tx;
    end
    repeat (DIV) @(negedge clk);
    chk(tx === 1'b1, "R1 stop bit high", int'(tx), 1);
  endtask

  task automatic wait_de(input logic lvl, output int c);
    bit seen = 1'b0;
    c = -1;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (de === lvl) begin
        seen = 1'b1;
        c = cyc;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tx === 1'b1, "R11 tx idle", int'(tx), 1);
    chk(de === ~pol, "R11 de receive", int'(de), int'(~pol));
    chk(empty === 1'b1, "R11 empty", int'(empty), 1);
    chk(full === 1'b0, "R11 full", int'(full), 0);
    chk(ovf === 1'b0, "R11 overflow", int'(ovf), 0);
  endtask

  task automatic t_single();
    logic [7:0] b;
    int f, de_c, drop;
    write_byte(8'hA5);
    de_c = cyc;
    chk(de === 1'b1, "R2 de active after write", int'(de), 1);
    chk(empty === 1'b0, "R9 not empty after write", int'(empty), 0);
    recv_byte(b, f);
    chk(b == 8'hA5, "R1 byte A5", int'(b), 'hA5);
    chk(f - de_c >= DIV, "R4 lead of one bit", f - de_c, DIV);
    wait_de(1'b0, drop);
    chk(drop - f == 13 * DIV, "R3 guard length", drop - f, 13 * DIV);
    chk(tx === 1'b1, "R1 idle after frame", int'(tx), 1);
  endtask

  task automatic t_b2b();
    logic [7:0] b1, b2;
    int f1, f2, drop;
    gap = 0; watch_lvl = 1'b1;
    write_byte(8'h3C);
    watch_en = 1'b1;
    write_byte(8'hC3);
    recv_byte(b1, f1);
    recv_byte(b2, f2);
    watch_en = 1'b0;
    chk(b1 == 8'h3C, "R5 first byte", int'(b1), 'h3C);
    chk(b2 == 8'hC3, "R5 second byte", int'(b2), 'hC3);
    chk(f2 - f1 == 10 * DIV, "R5 frames adjacent", f2 - f1, 10 * DIV);
    chk(gap == 0, "R5 de held", gap, 0);
    wait_de(1'b0, drop);
    chk(drop - f2 == 13 * DIV, "R3 guard after burst", drop - f2, 13 * DIV);
  endtask

  task automatic t_cancel();
    logic [7:0] b1, b2;
    int f1, f2, drop;
    gap = 0; watch_lvl = 1'b1;
    write_byte(8'h5A);
    watch_en = 1'b1;
    recv_byte(b1, f1);
    while (cyc < f1 + 11 * DIV + 2) @(negedge clk);
    chk(de === 1'b1, "R3 de held in guard", int'(de), 1);
    write_byte(8'h96);
    recv_byte(b2, f2);
    watch_en = 1'b0;
    chk(b1 == 8'h5A, "R6 first byte", int'(b1), 'h5A);
    chk(b2 == 8'h96, "R6 byte after cancel", int'(b2), 'h96);
    chk(gap == 0, "R6 no de gap", gap, 0);
    wait_de(1'b0, drop);
    chk(drop - f2 == 13 * DIV, "R6 fresh guard", drop - f2, 13 * DIV);
  endtask

  task automatic t_pol();
    logic [7:0] b;
    int f, drop;
    @(negedge clk);
    pol = 1'b0;
    @(negedge clk);
    chk(de === 1'b1, "R7 low-active idle level", int'(de), 1);
    write_byte(8'h0F);
    chk(de === 1'b0, "R7 low-active transmit level", int'(de), 0);
    recv_byte(b, f);
    chk(b == 8'h0F, "R7 byte", int'(b), 'h0F);
    wait_de(1'b1, drop);
    chk(drop - f == 13 * DIV, "R7 release timing", drop - f, 13 * DIV);
    pol = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_hwdis();
    logic [7:0] b;
    int f;
    @(negedge clk);
    hw_en = 1'b0;
    gap = 0; watch_lvl = 1'b0; watch_en = 1'b1;
    write_byte(8'h81);
    recv_byte(b, f);
    repeat (5 * DIV) @(negedge clk);
    watch_en = 1'b0;
    chk(b == 8'h81, "R8 frame sent while disabled", int'(b), 'h81);
    chk(gap == 0, "R8 de held at receive", gap, 0);
    hw_en = 1'b1;
    @(negedge clk);
    chk(de === 1'b0, "R8 de receive after re-enable", int'(de), 0);
  endtask

  task automatic t_ovf();
    logic [7:0] b;
    int f, drop;
    bit all_ok = 1'b1;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      wr = 1'b1;
      wdata = 8'(i);
    end
    @(negedge clk);
    wr = 1'b0;
    chk(full === 1'b1, "R9 full at 16", int'(full), 1);
    chk(ovf === 1'b1, "R10 overflow set", int'(ovf), 1);
    for (int i = 0; i < 17; i++) begin
      recv_byte(b, f);
      if (b != 8'(i)) begin
        all_ok = 1'b0;
        chk(1'b0, "R10 queued byte order", int'(b), i);
      end
    end
    chk(all_ok, "R10 17 bytes kept in order", int'(all_ok), 1);
    wait_de(1'b0, drop);
    chk(drop - f == 13 * DIV, "R10 last byte was 16th (no extra frame)", drop - f, 13 * DIV);
    chk(empty === 1'b1, "R9 empty after drain", int'(empty), 1);
    chk(ovf === 1'b1, "R10 overflow sticky", int'(ovf), 1);
    do_reset();
    chk(ovf === 1'b0, "R11 overflow cleared by reset", int'(ovf), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: all requirements, actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_single();
    t_b2b();
    t_cancel();
    t_pol();
    t_hwdis();
    t_ovf();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule